// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one column command into the run of column addresses that a memory burst visits. When a read or write command is taken, the start column is captured together with the burst settings: a length code, an order bit, and a flag that limits writes to one beat. From the next clock on, the block presents one column per cycle with a valid flag. A last flag marks the final beat of any burst that has a fixed length.

Addresses are reordered inside an aligned window whose size is the burst length. Sequential order counts upward and wraps inside the window. Interleave order XORs the start offset with the beat number. Column bits above the window keep their start value. A full-page burst walks all column positions and wraps at the end of the page. It runs until a stop pulse or a new command ends it. A new command may arrive on any clock, and it restarts the sequence from its own column.

Top module: `burst_col_gen`

## Requirements
- R1: The length code `len_code_i` selects 1 beat (3'b000), 2 beats (3'b001), 4 beats (3'b010), 8 beats (3'b011) or full page (3'b111). A start with code 3'b100, 3'b101 or 3'b110 that is not a single-beat write produces no beats: `valid_o` is low in the next cycle, and any burst in progress ends.
- R2: One cycle after a start strobe with an accepted code, `valid_o` is high and `col_o` equals the captured start column.
- R3: With `ilv_i`=0 and a finite length N, beat k shows `col_o[2:0]`-level offset (start mod N + k) mod N inside the N-aligned window that holds the start column.
- R4: With `ilv_i`=1 and a finite length N, beat k shows offset (start mod N) XOR k inside the same N-aligned window.
- R5: The column bits above the burst window hold their start value for every beat of a finite burst.
- R6: `last_o` is high only on the final beat of a finite burst, and only together with `valid_o`. In the cycle after that beat `valid_o` is low, unless a new start was taken.
- R7: A full-page burst always uses sequential order, whatever `ilv_i` says. It steps `col_o` by one modulo 1024 on each cycle, wraps past column 1023, never raises `last_o`, and continues until a stop or a new start.
- R8: When `single_wr_i`=1, a start with `is_write_i`=1 gives exactly one beat with `last_o` high, whatever the length code. Reads still use the programmed length. With `single_wr_i`=0, writes use the programmed length too.
- R9: A `stop_i` pulse during a burst drops `valid_o` in the next cycle. If `start_i` is high in the same cycle, the start wins.
- R10: A start during a burst abandons the old burst. The next cycle shows beat 0 of the new burst.
- R11: During and right after reset, `valid_o` and `last_o` are low and `col_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Column command strobe, captures the start column and the settings |
| start_col_i | input | 10 | Start column of the burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Order select: 0 sequential, 1 interleave |
| single_wr_i | input | 1 | When 1, writes are one beat long |
| is_write_i | input | 1 | 1 for a write command, 0 for a read |
| stop_i | input | 1 | Burst stop pulse |
| col_o | output | 10 | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
Suppose the beat counter or the captured window mask holds a wrong value. The fault shows on `col_o` in the first beat after it, or on `last_o` and `valid_o` in the cycle the burst should end. A wrong captured start shows up on beat 0, one cycle after the strobe. Bursts are swept over every finite length, both orders and every start offset inside the window, with different high bits. Any such mismatch is seen within at most eight beats. A full-page run past the wrap point exposes a counter that saturates, or one that wraps at the wrong place, within one page of cycles.

// File: rtl/burst_pkg.sv
// Shared constants for the burst column address generator.
// Assumes the length code is three bits wide and has fixed code points.
package burst_pkg;

    localparam int LEN_CODE_W = 3;

    typedef enum logic [LEN_CODE_W-1:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

endpackage

// File: rtl/burst_len_decode.sv
// Decodes the burst settings into a window mask, a full-page flag,
// an effective order bit and an accept flag.
// Assumes COL_W >= 3 so that an 8-beat window fits in the column.
module burst_len_decode
    import burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    input  logic                  single_wr_i,
    input  logic                  is_write_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  full_o,
    output logic                  ilv_o,
    output logic                  ok_o
);

    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    // Map the length code (or a forced single write) to a window.
    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        ok_o   = 1'b1;
        if (single_wr_i && is_write_i) begin
            mask_o = '0;
        end else begin
            case (len_code_i)
                LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EIGHT:
                    mask_o = ~(ALL_ONES << len_code_i[1:0]);
                LEN_PAGE: begin
                    mask_o = ALL_ONES;
                    full_o = 1'b1;
                end
                default: ok_o = 1'b0;
            endcase
        end
    end

    // Full page runs sequential only.
    always_comb ilv_o = ilv_i && !full_o;

endmodule

// File: rtl/burst_beat_seq.sv
// Holds the captured burst and counts beats. A start always takes
// priority, then a stop, then normal stepping. Finite bursts end after
// the beat whose index equals the window mask; full page never ends
// by itself.
module burst_beat_seq #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] mask_d_i,
    input  logic             full_d_i,
    input  logic             ilv_d_i,
    input  logic             ok_d_i,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic             active_o,
    output logic             last_o
);

    logic             active_q;
    logic             full_q;
    logic             ilv_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic             at_end;

    // Final beat of a finite burst.
    always_comb at_end = active_q && !full_q && (beat_q == mask_q);

    // Capture, stop and step the burst state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            full_q   <= 1'b0;
            ilv_q    <= 1'b0;
            base_q   <= '0;
            beat_q   <= '0;
            mask_q   <= '0;
        end else if (start_i) begin
            active_q <= ok_d_i;
            full_q   <= full_d_i;
            ilv_q    <= ilv_d_i;
            base_q   <= start_col_i;
            beat_q   <= '0;
            mask_q   <= mask_d_i;
        end else if (stop_i) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (at_end) active_q <= 1'b0;
            else        beat_q   <= beat_q + 1'b1;
        end
    end

    // Present the captured state.
    always_comb begin
        base_o   = base_q;
        beat_o   = beat_q;
        mask_o   = mask_q;
        ilv_o    = ilv_q;
        active_o = active_q;
        last_o   = at_end;
    end

endmodule

// File: rtl/burst_addr_order.sv
// Forms the column for a beat. The bits outside the window come from
// the start column. The bits inside come from a wrapping sum
// (sequential) or from an XOR with the beat index (interleave).
module burst_addr_order #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] ilv_mix;
    logic [COL_W-1:0] low_part;

    // Candidate offsets for both orders.
    always_comb begin
        seq_sum = base_i + beat_i;
        ilv_mix = base_i ^ beat_i;
    end

    // Merge the fixed high bits with the selected offset.
    always_comb begin
        low_part = ilv_i ? ilv_mix : seq_sum;
        col_o    = (base_i & ~mask_i) | (low_part & mask_i);
    end

endmodule

// File: rtl/burst_col_gen.sv
// Top of the burst column address generator. Decodes the settings on a
// start strobe, sequences beats and emits one column per cycle, with
// valid and last flags. Assumes the settings are valid with start_i.
module burst_col_gen
    import burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    input  logic                  single_wr_i,
    input  logic                  is_write_i,
    input  logic                  stop_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o
);

    logic [COL_W-1:0] mask_d;
    logic             full_d;
    logic             ilv_d;
    logic             ok_d;
    logic [COL_W-1:0] base_w;
    logic [COL_W-1:0] beat_w;
    logic [COL_W-1:0] mask_w;
    logic             ilv_w;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code_i  (len_code_i),
        .ilv_i       (ilv_i),
        .single_wr_i (single_wr_i),
        .is_write_i  (is_write_i),
        .mask_o      (mask_d),
        .full_o      (full_d),
        .ilv_o       (ilv_d),
        .ok_o        (ok_d)
    );

    burst_beat_seq #(.COL_W(COL_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .start_col_i (start_col_i),
        .mask_d_i    (mask_d),
        .full_d_i    (full_d),
        .ilv_d_i     (ilv_d),
        .ok_d_i      (ok_d),
        .base_o      (base_w),
        .beat_o      (beat_w),
        .mask_o      (mask_w),
        .ilv_o       (ilv_w),
        .active_o    (valid_o),
        .last_o      (last_o)
    );

    burst_addr_order #(.COL_W(COL_W)) u_ord (
        .base_i (base_w),
        .beat_i (beat_w),
        .mask_i (mask_w),
        .ilv_i  (ilv_w),
        .col_o  (col_o)
    );

endmodule

// File: rtl/burst_col_gen_chk.sv
// Port-level checks for the burst column address generator, bound to
// every instance of the top module.
module burst_col_gen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             single_wr_i,
    input logic             is_write_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);

    logic one_wr;
    logic code_ok;

    // Classify the settings seen with a start strobe.
    always_comb begin
        one_wr  = single_wr_i && is_write_i;
        code_ok = (len_code_i[2] == 1'b0) || (len_code_i == 3'b111);
    end

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !last_o));

    // R6
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R6
    end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    // R9
    stop_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o);

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (code_ok || one_wr)) |=> (valid_o && col_o == $past(start_col_i)));

    // R1
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !code_ok && !one_wr) |=> !valid_o);

    // R8
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && one_wr) |=> (valid_o && last_o));

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .single_wr_i (single_wr_i),
    .is_write_i  (is_write_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/sim_burst_col_gen.sv
// Sweeping bench for burst_col_gen; expected columns are computed
// arithmetically from the requirements.
module sim_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [9:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       single_wr_i = 1'b0;
    logic       is_write_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [9:0] col_o;
    logic       valid_o;
    logic       last_o;

    int n_run = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    burst_col_gen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .single_wr_i(single_wr_i),
        .is_write_i(is_write_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int k, input int n, input bit ilv);
        int off;
        int lo;
        off = s % n;
        lo  = ilv ? (off ^ k) : ((off + k) % n);
        return (s - off) + lo;
    endfunction

    // Issue a start and strobe it for one cycle; ends at the negedge of beat 0.
    task automatic issue(input int s, input int code, input bit ilv, input bit sw, input bit wr);
        start_i = 1'b1; start_col_i = 10'(s); len_code_i = 3'(code);
        ilv_i = ilv; single_wr_i = sw; is_write_i = wr;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Check n beats starting at the current negedge, then idle.
    task automatic expect_burst(input int s, input int n, input bit ilv, input string req);
        for (int k = 0; k < n; k++) begin
            check(valid_o, req, valid_o, 1);
            check(col_o == 10'(exp_col(s, k, n, ilv)), req, col_o, exp_col(s, k, n, ilv));
            check(last_o == (k == n - 1), "R6", last_o, k == n - 1);
            @(negedge clk);
        end
        check(!valid_o, "R6", valid_o, 0);
    endtask

    initial begin
        #1_600_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!valid_o && !last_o, "R11", valid_o, 0);
        check(col_o == 0, "R11", col_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 sweep over lengths, orders and start offsets
        for (int code = 0; code < 4; code++)
            for (int il = 0; il < 2; il++)
                for (int off = 0; off < 8; off++) begin
                    int s;
                    s = ((off * 37 + code * 91 + il * 200) & 10'h3f8) | off;
                    issue(s, code, il[0], 1'b0, 1'b0);
                    expect_burst(s, 1 << code, il[0], il ? "R4" : "R3");
                end
        // R5 high bits near top of page stay fixed
        issue(1022, 3, 1'b0, 1'b0, 1'b0);
        expect_burst(1022, 8, 1'b0, "R5");

        // R7 full page, interleave bit ignored, wraps, no last, stop ends
        issue(1020, 7, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 1030; k++) begin
            check(valid_o && !last_o, "R7", last_o, 0);
            check(col_o == 10'((1020 + k) % 1024), "R7", col_o, (1020 + k) % 1024);
            @(negedge clk);
        end
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check(!valid_o, "R9", valid_o, 0);

        // R1 reserved codes give no beats, and end a running burst
        for (int code = 4; code < 7; code++) begin
            issue(100, code, 1'b0, 1'b0, 1'b0);
            check(!valid_o, "R1", valid_o, 0);
        end
        issue(40, 3, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        issue(40, 5, 1'b0, 1'b0, 1'b0);
        check(!valid_o, "R1", valid_o, 0);

        // R8 single-beat writes, reads keep length, mode off keeps length
        issue(77, 3, 1'b0, 1'b1, 1'b1);
        expect_burst(77, 1, 1'b0, "R8");
        issue(77, 7, 1'b0, 1'b1, 1'b1);
        expect_burst(77, 1, 1'b0, "R8");
        issue(77, 3, 1'b1, 1'b1, 1'b0);
        expect_burst(77, 8, 1'b1, "R8");
        issue(77, 2, 1'b0, 1'b0, 1'b1);
        expect_burst(77, 4, 1'b0, "R8");

        // R9 stop mid-burst
        issue(3, 3, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check(!valid_o, "R9", valid_o, 0);
        // R9 start wins over stop in same cycle
        stop_i = 1'b1;
        issue(200, 1, 1'b0, 1'b0, 1'b0);
        stop_i = 1'b0;
        expect_burst(200, 2, 1'b0, "R9");

        // R10 restart mid-burst
        issue(16, 3, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        issue(513, 1, 1'b0, 1'b0, 1'b0);
        expect_burst(513, 2, 1'b0, "R10");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule